// File: doc/BRIEF.md
# Quad Trim-DAC Serial Register Core

This block is the digital side of a four-channel, 8-bit trim converter. A host reaches it over a three-wire serial port: a clock, a select line and one data input. A returning serial data line is enabled only while the select line is high. Every frame is an exchange. The host shifts in a channel address and a new 8-bit code. While the new code goes in, the block shifts the channel's present code back out. The old code is consumed by that exchange.

Each channel has two registers. One is a temporary working value. The other is a persistent stored value, modelled here as a register array with a commit port. A code written by a frame is only temporary: it drives the channel output until the select line drops. At that point every channel falls back to its stored value. A code becomes persistent only when the programming strobe rises inside the frame, is still high on the clock after the last data bit, and stays high for a set number of clock cycles. At power-on reset the outputs take the stored values and need no clock edge to do so.

Top module: `trimdac_core`

## Requirements
- R1: A frame starts when the port samples `di`=1 on a rising `clk` edge with `cs` high. The next two edges sample address bits A0 then A1, and the eight edges after that sample data bits D0 to D7, least significant first. Edges that sample `di`=0 while waiting for a start bit are ignored.
- R2: The address value A0 + 2*A1 selects channel k (0 to 3). Channel k's present code appears on `dac_code[8k+7:8k]`.
- R3: After the edge that samples A1, `do_o` shows bit 0 of the addressed channel's present code. After each following data edge it shows the next bit. The host therefore reads old bit i at the same edge that samples new bit Di.
- R4: The addressed channel's output changes to the new code on the edge after the one that sampled D7, and not before.
- R5: `do_oe` is 1 exactly while `cs` is high. When it is 0, `do_o` is 0.
- R6: When `cs` falls, all four outputs show their stored values at once, with no clock edge needed. Temporary codes written before that point do not come back when `cs` rises again.
- R7: The two edges after D7 never begin a frame, even if `di` is 1. A start bit is accepted on the third edge after D7.
- R8: A channel's stored value takes the new code when all of these hold: `prog` rises after the start-bit edge, `prog` is high on the edge after D7, and `prog` stays high for the next PROG_CYCLES edges. The update happens on the last of those edges. If no qualifying `prog` arrives, the stored value is left unchanged.
- R9: If `prog` falls before PROG_CYCLES edges have passed, the commit is dropped and the stored value is unchanged.
- R10: If `prog` was already high before the start bit and does not rise again inside the frame, no commit happens.
- R11: While `rst_n` is low, `dac_code` equals INIT_CODES. After reset the stored values are INIT_CODES.
- R12: If `cs` goes low partway through a frame, the frame is abandoned. The next frame after `cs` rises again decodes from a fresh start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all sampling is on the rising edge |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| cs | input | 1 | Select; high enables the port, low restores stored codes |
| di | input | 1 | Serial data in |
| prog | input | 1 | Programming strobe for a persistent commit |
| do_o | output | 1 | Serial data out (old code of the addressed channel) |
| do_oe | output | 1 | Output enable for `do_o`; low means high impedance |
| dac_code | output | 32 | Four 8-bit channel codes, channel 0 in the low byte |

## Verification
The bench targets the two clocks of dead time after D7. A design that accepted a start bit there would misalign the next frame and write the wrong channel. It drives `prog` in three ways: rising inside the frame and held long enough, released early, and already high before the start bit. A design that treats any level of `prog` as a request would commit in the last two cases and corrupt the stored code. It drops `cs` in the middle of a frame and between frames. This checks that outputs fall back with no clock edge, and that a half-received frame does not shift later bits into the wrong field. Each read-back value is compared with the code the bench last wrote or restored. This catches a shift register that returns the new data instead of the old.

// File: rtl/trimdac_pkg.sv
package trimdac_pkg;

    // Frame receiver states
    typedef enum logic [2:0] {
        FS_IDLE = 3'd0,   // waiting for a start bit
        FS_ADDR = 3'd1,   // collecting address bits
        FS_DATA = 3'd2,   // exchanging data bits
        FS_LOAD = 3'd3,   // edge after D7: output update, commit decision
        FS_GAP  = 3'd4,   // second dead edge after D7
        FS_PROG = 3'd5    // holding a persistent commit
    } fstate_e;

endpackage

// File: rtl/trimdac_framer.sv
module trimdac_framer
    import trimdac_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int CODE_W      = 8,
    parameter int PROG_CYCLES = 3000
) (
    input  logic                        clk,
    input  logic                        arst_n,     // low on reset or cs low
    input  logic                        di,
    input  logic                        prog,
    input  logic [(1<<ADDR_W)*CODE_W-1:0] chan_flat,
    output logic                        do_bit,
    output logic                        wr_en,
    output logic [ADDR_W-1:0]           wr_ch,
    output logic [CODE_W-1:0]           wr_val,
    output logic                        cm_en,
    output logic [ADDR_W-1:0]           cm_ch,
    output logic [CODE_W-1:0]           cm_val
);

    localparam int MAXF  = (CODE_W > ADDR_W) ? CODE_W : ADDR_W;
    localparam int CNT_W = $clog2(MAXF) + 1;
    localparam int PCW   = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;

    typedef struct packed {
        fstate_e             st;
        logic [CNT_W-1:0]    bcnt;
        logic [ADDR_W-1:0]   acc;
        logic [ADDR_W-1:0]   ch;
        logic [CODE_W-1:0]   sh;
        logic                armed;
        logic                prog_prev;
        logic [PCW-1:0]      pcnt;
    } fr_t;

    fr_t q, d;
    logic              rise;
    logic [ADDR_W:0]   ext;
    logic [ADDR_W-1:0] new_addr;

    always_comb begin
        d        = q;
        d.prog_prev = prog;
        rise     = prog & ~q.prog_prev;
        ext      = {di, q.acc};
        new_addr = ext[ADDR_W:1];
        case (q.st)
            FS_IDLE: begin
                if (di) begin
                    d.st    = FS_ADDR;
                    d.bcnt  = '0;
                    d.armed = 1'b0;
                end
            end
            FS_ADDR: begin
                d.acc = new_addr;
                if (rise) d.armed = 1'b1;
                if (q.bcnt == CNT_W'(ADDR_W - 1)) begin
                    d.st   = FS_DATA;
                    d.bcnt = '0;
                    d.ch   = new_addr;
                    d.sh   = chan_flat[new_addr*CODE_W +: CODE_W];
                end else begin
                    d.bcnt = q.bcnt + 1'b1;
                end
            end
            FS_DATA: begin
                d.sh = {di, q.sh[CODE_W-1:1]};
                if (rise) d.armed = 1'b1;
                if (q.bcnt == CNT_W'(CODE_W - 1)) begin
                    d.st = FS_LOAD;
                end else begin
                    d.bcnt = q.bcnt + 1'b1;
                end
            end
            FS_LOAD: begin
                if (prog && (q.armed || rise)) begin
                    d.st   = FS_PROG;
                    d.pcnt = '0;
                end else begin
                    d.st = FS_GAP;
                end
            end
            FS_GAP: begin
                d.st = FS_IDLE;
            end
            FS_PROG: begin
                if (!prog) begin
                    d.st = FS_IDLE;
                end else if (q.pcnt == PCW'(PROG_CYCLES - 1)) begin
                    d.st = FS_IDLE;
                end else begin
                    d.pcnt = q.pcnt + 1'b1;
                end
            end
            default: d.st = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) q <= '0;
        else         q <= d;
    end

    assign do_bit = (q.st == FS_DATA) & q.sh[0];
    assign wr_en  = (q.st == FS_LOAD);
    assign wr_ch  = q.ch;
    assign wr_val = q.sh;
    assign cm_en  = (q.st == FS_PROG) && prog && (q.pcnt == PCW'(PROG_CYCLES - 1));
    assign cm_ch  = q.ch;
    assign cm_val = q.sh;

    // R7
    load_then_dead_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (q.st == FS_LOAD) |=> (q.st == FS_GAP || q.st == FS_PROG));

    // R7
    gap_then_idle_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (q.st == FS_GAP) |=> (q.st == FS_IDLE));

    // R4
    last_bit_update_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (q.st == FS_DATA && q.bcnt == CNT_W'(CODE_W - 1)) |=> wr_en);

    // R9
    commit_needs_prog_chk: assert property (@(posedge clk) disable iff (!arst_n)
        cm_en |-> $past(prog));

endmodule

// File: rtl/trimdac_bank.sv
module trimdac_bank #(
    parameter int ADDR_W = 2,
    parameter int CODE_W = 8,
    parameter logic [(1<<ADDR_W)*CODE_W-1:0] INIT_CODES = '0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          live_rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_ch,
    input  logic [CODE_W-1:0]             wr_val,
    input  logic                          cm_en,
    input  logic [ADDR_W-1:0]             cm_ch,
    input  logic [CODE_W-1:0]             cm_val,
    output logic [(1<<ADDR_W)*CODE_W-1:0] chan_flat
);

    localparam int NCH = 1 << ADDR_W;

    typedef struct packed {
        logic [NCH-1:0][CODE_W-1:0] vol;
        logic [NCH-1:0][CODE_W-1:0] nv;
    } bank_t;

    bank_t q, d;
    logic [NCH-1:0] live_q, live_d;

    always_comb begin
        d = q;
        if (wr_en) d.vol[wr_ch] = wr_val;
        if (cm_en) d.nv[cm_ch]  = cm_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.vol <= INIT_CODES;
            q.nv  <= INIT_CODES;
        end else begin
            q <= d;
        end
    end

    // Temporary-value flags are cleared asynchronously whenever select drops
    always_comb begin
        live_d = live_q;
        if (wr_en) live_d[wr_ch] = 1'b1;
    end

    always_ff @(posedge clk or negedge live_rst_n) begin
        if (!live_rst_n) live_q <= '0;
        else             live_q <= live_d;
    end

    for (genvar k = 0; k < NCH; k++) begin : g_chan
        assign chan_flat[k*CODE_W +: CODE_W] = live_q[k] ? q.vol[k] : q.nv[k];
    end

    // R4
    write_visible_chk: assert property (@(posedge clk) disable iff (!live_rst_n)
        wr_en |=> (chan_flat[$past(wr_ch)*CODE_W +: CODE_W] == $past(wr_val)));

    // R8
    nv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cm_en |=> $stable(q.nv));

    // R8
    nv_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cm_en |=> (q.nv[$past(cm_ch)] == $past(cm_val)));

endmodule

// File: rtl/trimdac_core.sv
module trimdac_core #(
    parameter int ADDR_W      = 2,
    parameter int CODE_W      = 8,
    parameter int PROG_CYCLES = 3000,
    parameter logic [(1<<ADDR_W)*CODE_W-1:0] INIT_CODES = 32'hC080_4010
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cs,
    input  logic                          di,
    input  logic                          prog,
    output logic                          do_o,
    output logic                          do_oe,
    output logic [(1<<ADDR_W)*CODE_W-1:0] dac_code
);

    localparam int FLAT_W = (1 << ADDR_W) * CODE_W;

    logic              sel_rst_n;
    logic              do_bit;
    logic              wr_en, cm_en;
    logic [ADDR_W-1:0] wr_ch, cm_ch;
    logic [CODE_W-1:0] wr_val, cm_val;
    logic [FLAT_W-1:0] chan_flat;

    assign sel_rst_n = rst_n & cs;

    trimdac_framer #(
        .ADDR_W      (ADDR_W),
        .CODE_W      (CODE_W),
        .PROG_CYCLES (PROG_CYCLES)
    ) u_framer (
        .clk       (clk),
        .arst_n    (sel_rst_n),
        .di        (di),
        .prog      (prog),
        .chan_flat (chan_flat),
        .do_bit    (do_bit),
        .wr_en     (wr_en),
        .wr_ch     (wr_ch),
        .wr_val    (wr_val),
        .cm_en     (cm_en),
        .cm_ch     (cm_ch),
        .cm_val    (cm_val)
    );

    trimdac_bank #(
        .ADDR_W     (ADDR_W),
        .CODE_W     (CODE_W),
        .INIT_CODES (INIT_CODES)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .live_rst_n (sel_rst_n),
        .wr_en      (wr_en),
        .wr_ch      (wr_ch),
        .wr_val     (wr_val),
        .cm_en      (cm_en),
        .cm_ch      (cm_ch),
        .cm_val     (cm_val),
        .chan_flat  (chan_flat)
    );

    assign do_oe    = cs;
    assign do_o     = cs & do_bit;
    assign dac_code = chan_flat;

    // R5
    quiet_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !do_oe |-> !do_o);

endmodule

// File: tb/tb_trimdac_core.sv
module tb_trimdac_core;

    localparam int CLK_PERIOD = 10;
    localparam int PCYC       = 6;
    localparam logic [31:0] INIT = 32'hC080_4010;

    // table entries: {prog, ch[1:0], val[7:0]}
    localparam logic [10:0] VEC [8] = '{
        11'h05A, 11'h1A5, 11'h23C, 11'h3FF,
        11'h600, 11'h081, 11'h57E, 11'h301
    };

    logic        clk = 1'b0;
    logic        rst_n, cs, di, prog;
    logic        do_o, do_oe;
    logic [31:0] dac_code;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;
    logic [7:0] cur [4];
    logic [7:0] nv  [4];
    logic [7:0] rd;

    trimdac_core #(.PROG_CYCLES(PCYC), .INIT_CODES(INIT)) dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .di(di), .prog(prog),
        .do_o(do_o), .do_oe(do_oe), .dac_code(dac_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] flat_cur();
        logic [31:0] v;
        for (int k = 0; k < 4; k++) v[k*8 +: 8] = cur[k];
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic step(input logic b);
        di = b;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic restore_model();
        for (int k = 0; k < 4; k++) cur[k] = nv[k];
    endtask

    // Sends one frame; pg_hold>0 raises prog inside the frame and holds it
    task automatic send_frame(input logic [1:0] ch, input logic [7:0] val,
                              input int pg_hold, input logic gapbit,
                              output logic [7:0] rdv);
        step(1'b1);
        step(ch[0]);
        step(ch[1]);
        for (int i = 0; i < 8; i++) begin
            rdv[i] = do_o;
            if (pg_hold > 0 && i == 1) prog = 1'b1;
            step(val[i]);
        end
        chk("R4 output held until edge after D7", dac_code, flat_cur());
        step(gapbit);
        if (pg_hold > 0) begin
            repeat (pg_hold) step(1'b0);
            prog = 1'b0;
            step(1'b0);
            step(1'b0);
        end else begin
            step(gapbit);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cs = 1'b0; di = 1'b0; prog = 1'b0;
        for (int k = 0; k < 4; k++) begin
            cur[k] = INIT[k*8 +: 8];
            nv[k]  = INIT[k*8 +: 8];
        end
        repeat (3) @(negedge clk);
        chk("R11 reset codes", dac_code, INIT);
        chk("R5 oe low when deselected", {31'd0, do_oe}, 32'd0);
        rst_n = 1'b1;
        step(1'b0);
        cs = 1'b1;
        #1;
        chk("R5 oe high when selected", {31'd0, do_oe}, 32'd1);
        @(negedge clk);

        // table walk: each entry exchanges and updates one channel
        for (int n = 0; n < 8; n++) begin
            logic       pg;
            logic [1:0] ch;
            logic [7:0] val;
            pg  = VEC[n][10];
            ch  = VEC[n][9:8];
            val = VEC[n][7:0];
            send_frame(ch, val, pg ? PCYC : 0, 1'b0, rd);
            chk("R3 old code read back", {24'd0, rd}, {24'd0, cur[ch]});
            cur[ch] = val;
            if (pg) nv[ch] = val;
            chk("R2 R4 channel update", dac_code, flat_cur());
        end

        // deselect: stored codes come back with no clock edge
        cs = 1'b0;
        #1;
        restore_model();
        chk("R6 immediate restore", dac_code, flat_cur());
        chk("R8 committed codes", dac_code, {8'hC0, 8'h00, 8'h7E, 8'h10});
        chk("R5 oe follows cs", {31'd0, do_oe}, 32'd0);
        @(negedge clk);
        step(1'b0);
        cs = 1'b1;
        #1;
        chk("R6 temp codes not revived", dac_code, flat_cur());
        @(negedge clk);

        // idle zeros before a start bit are ignored
        repeat (5) step(1'b0);
        send_frame(2'd0, 8'h33, 0, 1'b0, rd);
        chk("R1 read after idle", {24'd0, rd}, {24'd0, cur[0]});
        cur[0] = 8'h33;
        chk("R1 frame after idle", dac_code, flat_cur());

        // dead edges after D7 carry di=1 and must not start a frame
        send_frame(2'd1, 8'h44, 0, 1'b1, rd);
        cur[1] = 8'h44;
        send_frame(2'd2, 8'h99, 0, 1'b0, rd);
        chk("R7 read of ch2", {24'd0, rd}, {24'd0, cur[2]});
        cur[2] = 8'h99;
        chk("R7 two frames decode", dac_code, flat_cur());

        // early release of prog: no commit
        send_frame(2'd3, 8'hA7, 3, 1'b0, rd);
        cur[3] = 8'hA7;
        chk("R9 temp value shown", dac_code, flat_cur());

        // prog already high before start: no commit
        prog = 1'b1;
        step(1'b0);
        send_frame(2'd1, 8'h5C, 0, 1'b0, rd);
        repeat (PCYC + 2) step(1'b0);
        prog = 1'b0;
        step(1'b0);
        cur[1] = 8'h5C;
        chk("R10 temp value shown", dac_code, flat_cur());

        cs = 1'b0;
        #1;
        restore_model();
        chk("R9 store unchanged after abort", {24'd0, dac_code[31:24]}, 32'h0000_00C0);
        chk("R10 store unchanged without rise", {24'd0, dac_code[15:8]}, 32'h0000_007E);
        @(negedge clk);
        step(1'b0);

        // select dropped partway through a frame
        cs = 1'b1;
        @(negedge clk);
        step(1'b1); step(1'b1); step(1'b0); step(1'b1); step(1'b1);
        cs = 1'b0;
        step(1'b0);
        cs = 1'b1;
        @(negedge clk);
        send_frame(2'd3, 8'h6C, 0, 1'b0, rd);
        chk("R12 read after abandon", {24'd0, rd}, {24'd0, cur[3]});
        cur[3] = 8'h6C;
        chk("R12 fresh frame decodes", dac_code, flat_cur());

        // a second commit on another channel, then restore
        send_frame(2'd0, 8'hE1, PCYC, 1'b0, rd);
        nv[0] = 8'hE1;
        cs = 1'b0;
        #1;
        restore_model();
        chk("R8 commit on ch0", dac_code, flat_cur());

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule